// File: doc/BRIEF.md
# Indirect-Operand Add Executor

This block runs a single 16-bit add instruction over a bank of eight general registers. The instruction names a destination and two sources, and each of the three names carries its own indirect flag. When a source flag is clear, the register's value is the addend. When it is set, the register's value is a memory address, and the word stored at that address is the addend. The destination follows the same rule: a clear flag writes the sum into the register, and a set flag writes the sum to memory at the address the register holds.

A small sequencer issues one synchronous memory read for each indirect source, taking the first source before the second, and then commits the result. Because each flag is chosen on its own, the instruction length varies from one to five cycles. A host loads the registers through a load port while the block is idle and reads them back through a combinational inspection port. It presents an instruction when `ready` is high and waits for the `done` pulse before presenting the next one. Any opcode other than the add raises a one-cycle illegal flag and changes nothing.

Top module: `ind_add_exec`

## Requirements
- R1: The instruction layout is opcode in [15:12], destination indirect flag in [11], destination register in [10:8], first-source indirect flag in [7], first-source register in [6:4], second-source indirect flag in [3] and second-source register in [2:0]. Opcode 4'b0000 is the add.
- R2: A source whose flag is 0 uses the register contents. A source whose flag is 1 drives `mem_rd` with `mem_addr` equal to the register contents, and uses `mem_rdata` as it stands one cycle later.
- R3: The result is the sum of the two operands modulo 2^DATA_W, so any carry out is dropped.
- R4: A destination flag of 0 writes the sum into the destination register. A flag of 1 raises `mem_wr` for one cycle, with `mem_addr` equal to the destination register contents and `mem_wdata` equal to the sum, and leaves every register unchanged.
- R5: With k indirect sources (0, 1 or 2), `done` rises 1+2k clock edges after the edge that accepts the instruction. When both sources are indirect, the first memory read uses the first source's address.
- R6: `done` is a single-cycle pulse. `ready` is high only while the block is idle. An instruction presented while `ready` is low is ignored.
- R7: An accepted instruction with a nonzero opcode raises `illegal` for exactly one cycle on the next edge. It produces no `done`, no memory write and no register change, and the block stays ready.
- R8: `cfg_we` writes `cfg_wdata` into register `cfg_idx` only while `ready` is high; it is ignored while an instruction is executing. `dbg_data` always shows register `dbg_idx` combinationally.
- R9: After reset every register reads 0, `ready` is 1, and `done`, `illegal`, `mem_rd` and `mem_wr` are 0.
- R10: `mem_rd` and `mem_wr` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Instruction present |
| instr | input | 16 | Instruction word |
| ready | output | 1 | Idle; an instruction is accepted this cycle |
| done | output | 1 | Result committed (one-cycle pulse) |
| illegal | output | 1 | Rejected opcode (one-cycle pulse) |
| mem_rd | output | 1 | Memory read request |
| mem_wr | output | 1 | Memory write request |
| mem_addr | output | DATA_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after `mem_rd` |
| cfg_we | input | 1 | Register load strobe |
| cfg_idx | input | 3 | Register load index |
| cfg_wdata | input | DATA_W | Register load value |
| dbg_idx | input | 3 | Register inspection index |
| dbg_data | output | DATA_W | Register inspection value |

## Verification
The hardest situation to reach from the ports is an access in which the same register appears in several roles with different flags. One example is a register serving both as a direct addend and as the address of the other addend. Another is an indirect destination that aliases a source register, which must not disturb that register. The bench reaches every such pairing by sweeping all 4096 combinations of flags and register numbers under the add opcode. Before each instruction it reloads the bank with values that serve as valid memory addresses, so every alias lands on a known memory word. A further sequence loads a register and presents a second instruction while the block is busy, showing that neither takes effect.

// File: rtl/ind_add_pkg.sv
package ind_add_pkg;
  localparam int INSTR_W = 16;
  localparam int OPC_W   = 4;
  localparam int RNUM_W  = 3;
  localparam logic [OPC_W-1:0] OPC_ADD = 4'b0000;

  typedef struct packed {
    logic [OPC_W-1:0]  opc;
    logic              d_ind;
    logic [RNUM_W-1:0] d_reg;
    logic              a_ind;
    logic [RNUM_W-1:0] a_reg;
    logic              b_ind;
    logic [RNUM_W-1:0] b_reg;
  } instr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RDA, ST_LDA, ST_RDB, ST_LDB, ST_EXEC
  } state_t;
endpackage

// File: rtl/ind_add_regs.sv
module ind_add_regs #(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [IDX_W-1:0]  widx,
  input  logic [DATA_W-1:0] wdata,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic [IDX_W-1:0]  rd_idx,
  input  logic [IDX_W-1:0]  rx_idx,
  output logic [DATA_W-1:0] ra,
  output logic [DATA_W-1:0] rb,
  output logic [DATA_W-1:0] rd,
  output logic [DATA_W-1:0] rx
);
  logic [DATA_W-1:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q[g] <= '0;
      else if (we && widx == IDX_W'(g)) q[g] <= wdata;
    end
  end

  assign ra = q[ra_idx];
  assign rb = q[rb_idx];
  assign rd = q[rd_idx];
  assign rx = q[rx_idx];
endmodule

// File: rtl/ind_add_ctrl.sv
module ind_add_ctrl
  import ind_add_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   a_ind,
  input  logic   b_ind,
  output state_t state
);
  state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = a_ind ? ST_RDA : (b_ind ? ST_RDB : ST_EXEC);
      ST_RDA:  nxt = ST_LDA;
      ST_LDA:  nxt = b_ind ? ST_RDB : ST_EXEC;
      ST_RDB:  nxt = ST_LDB;
      ST_LDB:  nxt = ST_EXEC;
      ST_EXEC: nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/ind_add_exec.sv
module ind_add_exec
  import ind_add_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int NREG   = 8,
  localparam int IDX_W = $clog2(NREG)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              instr_valid,
  input  logic [INSTR_W-1:0] instr,
  output logic              ready,
  output logic              done,
  output logic              illegal,
  output logic              mem_rd,
  output logic              mem_wr,
  output logic [DATA_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic              cfg_we,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_wdata,
  input  logic [IDX_W-1:0]  dbg_idx,
  output logic [DATA_W-1:0] dbg_data
);
  function automatic logic [DATA_W-1:0] add_wrap(input logic [DATA_W-1:0] x,
                                                 input logic [DATA_W-1:0] y);
    return x + y;
  endfunction

  instr_t            in_w, cur;
  state_t            state;
  logic              accept, accept_add, accept_bad, commit_ev;
  logic              a_sel, b_sel;
  logic [DATA_W-1:0] op_a, op_b, sum;
  logic [DATA_W-1:0] rf_a, rf_b, rf_d;
  logic              rf_we;
  logic [IDX_W-1:0]  rf_widx;
  logic [DATA_W-1:0] rf_wdata;

  assign in_w       = instr_t'(instr);
  assign ready      = (state == ST_IDLE);
  assign accept     = instr_valid && ready;
  assign accept_add = accept && (in_w.opc == OPC_ADD);
  assign accept_bad = accept && (in_w.opc != OPC_ADD);
  assign commit_ev  = (state == ST_EXEC);
  assign a_sel      = ready ? in_w.a_ind : cur.a_ind;
  assign b_sel      = ready ? in_w.b_ind : cur.b_ind;

  ind_add_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(accept_add),
    .a_ind(a_sel), .b_ind(b_sel), .state(state)
  );

  assign rf_we    = (commit_ev && !cur.d_ind) || (cfg_we && ready);
  assign rf_widx  = commit_ev ? IDX_W'(cur.d_reg) : cfg_idx;
  assign rf_wdata = commit_ev ? sum : cfg_wdata;

  ind_add_regs #(.DATA_W(DATA_W), .NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(rf_we), .widx(rf_widx), .wdata(rf_wdata),
    .ra_idx(IDX_W'(ready ? in_w.a_reg : cur.a_reg)),
    .rb_idx(IDX_W'(ready ? in_w.b_reg : cur.b_reg)),
    .rd_idx(IDX_W'(cur.d_reg)),
    .rx_idx(dbg_idx),
    .ra(rf_a), .rb(rf_b), .rd(rf_d), .rx(dbg_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur     <= '0;
      op_a    <= '0;
      op_b    <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
    end else begin
      done    <= commit_ev;
      illegal <= accept_bad;
      if (accept_add) begin
        cur  <= in_w;
        op_a <= rf_a;
        op_b <= rf_b;
      end
      if (state == ST_LDA) op_a <= mem_rdata;
      if (state == ST_LDB) op_b <= mem_rdata;
    end
  end

  assign sum       = add_wrap(op_a, op_b);
  assign mem_rd    = (state == ST_RDA) || (state == ST_RDB);
  assign mem_wr    = commit_ev && cur.d_ind;
  assign mem_wdata = sum;
  assign mem_addr  = (state == ST_RDB) ? rf_b : (commit_ev ? rf_d : rf_a);
endmodule

// File: rtl/ind_add_chk.sv
module ind_add_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic accept_add,
  input logic accept_bad,
  input logic commit_ev,
  input logic done,
  input logic illegal,
  input logic mem_rd,
  input logic mem_wr
);
  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr)); // R10
  AST_RD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> !ready); // R2
  AST_WR_THEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |=> done); // R4
  AST_DONE_AFTER_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(commit_ev)); // R5
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    accept_add |=> !ready); // R6
  AST_BAD_OPC: assert property (@(posedge clk) disable iff (!rst_n)
    accept_bad |=> (illegal && ready && !done)); // R7
endmodule

bind ind_add_exec ind_add_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ready(ready),
  .accept_add(accept_add), .accept_bad(accept_bad), .commit_ev(commit_ev),
  .done(done), .illegal(illegal), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/sim_ind_add_exec.sv
module sim_ind_add_exec;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [15:0] instr = '0;
  logic        ready, done, illegal, mem_rd, mem_wr;
  logic [15:0] mem_addr, mem_wdata, mem_rdata, dbg_data;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_idx = '0, dbg_idx = '0;
  logic [15:0] cfg_wdata = '0;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ind_add_exec u0 (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr(instr),
    .ready(ready), .done(done), .illegal(illegal),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata),
    .dbg_idx(dbg_idx), .dbg_data(dbg_data)
  );

  // bench memory: one-cycle read latency, logs read addresses and write count
  logic [15:0] mem [256];
  logic [15:0] rd_log [16];
  int rd_cnt = 0;
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_rd) begin
      mem_rdata <= mem[mem_addr[7:0]];
      rd_log[rd_cnt % 16] <= mem_addr;
      rd_cnt <= rd_cnt + 1;
    end
    if (mem_wr) begin
      mem[mem_addr[7:0]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
  end

  function automatic logic [15:0] reg_val(int i, int seed);
    return 16'((i * 29 + seed * 7 + 3) & 255);
  endfunction
  function automatic logic [15:0] mem_val(int a);
    return 16'(a * 257 + 16'h9000);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic init_mem();
    for (int a = 0; a < 256; a++) mem[a] = mem_val(a);
  endtask

  task automatic load_regs(input int seed);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_idx = 3'(i); cfg_wdata = reg_val(i, seed);
    end
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic peek(input int i, output logic [15:0] v);
    dbg_idx = 3'(i);
    #1 v = dbg_data;
  endtask

  // drives one instruction; returns edges from accept to done
  task automatic issue(input logic [15:0] w, output int lat);
    @(negedge clk);
    instr_valid = 1'b1; instr = w;
    @(negedge clk);
    instr_valid = 1'b0;
    lat = 0;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] v, a, b, s;
    int lat, rs, ws;
    init_mem();
    repeat (3) @(negedge clk);
    // R9: reset state
    check(ready === 1'b1 && done === 1'b0 && illegal === 1'b0, "R9", {ready, done, illegal}, 3'b100);
    check(mem_rd === 1'b0 && mem_wr === 1'b0, "R9", {mem_rd, mem_wr}, 0);
    for (int i = 0; i < 8; i++) begin
      peek(i, v);
      check(v === 16'h0, "R9", v, 0);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R1 R2 R3 R4 R5: every flag and register combination of the add
    for (int k = 0; k < 4096; k++) begin
      logic [15:0] w;
      logic d_i, a_i, b_i;
      int d_r, a_r, b_r, nind;
      w = 16'(k);
      d_i = w[11]; d_r = int'(w[10:8]);
      a_i = w[7];  a_r = int'(w[6:4]);
      b_i = w[3];  b_r = int'(w[2:0]);
      init_mem();
      load_regs(k);
      a = a_i ? mem_val(int'(reg_val(a_r, k))) : reg_val(a_r, k);
      b = b_i ? mem_val(int'(reg_val(b_r, k))) : reg_val(b_r, k);
      s = a + b;
      nind = int'(a_i) + int'(b_i);
      rs = rd_cnt; ws = wr_cnt;
      issue(w, lat);
      check(lat == 1 + 2 * nind, "R5", lat, 1 + 2 * nind);
      check(rd_cnt - rs == nind, "R2", rd_cnt - rs, nind);
      if (a_i && b_i)
        check(rd_log[rs % 16] == reg_val(a_r, k), "R5", rd_log[rs % 16], reg_val(a_r, k));
      if (d_i) begin
        check(mem[reg_val(d_r, k)] === s, "R4", mem[reg_val(d_r, k)], s);
        check(wr_cnt - ws == 1, "R4", wr_cnt - ws, 1);
        for (int i = 0; i < 8; i++) begin
          peek(i, v);
          check(v === reg_val(i, k), "R4", v, reg_val(i, k));
        end
      end else begin
        peek(d_r, v);
        check(v === s, "R3", v, s);
        check(wr_cnt == ws, "R4", wr_cnt - ws, 0);
      end
      @(negedge clk);
      check(done === 1'b0, "R6", done, 0);
    end

    // R7: every non-add opcode
    for (int op = 1; op < 16; op++) begin
      load_regs(op + 77);
      ws = wr_cnt;
      @(negedge clk);
      instr_valid = 1'b1; instr = {4'(op), 12'h999};
      @(negedge clk);
      instr_valid = 1'b0;
      check(illegal === 1'b1 && done === 1'b0 && ready === 1'b1, "R7", {illegal, done, ready}, 3'b101);
      @(negedge clk);
      check(illegal === 1'b0 && done === 1'b0, "R7", {illegal, done}, 0);
      check(wr_cnt == ws, "R7", wr_cnt - ws, 0);
      for (int i = 0; i < 8; i++) begin
        peek(i, v);
        check(v === reg_val(i, op + 77), "R7", v, reg_val(i, op + 77));
      end
    end

    // R8 R6: load and second instruction while busy are both ignored
    init_mem();
    load_regs(5);
    @(negedge clk);
    instr_valid = 1'b1; instr = 16'h01A9;   // dest r1, both sources indirect
    @(negedge clk);
    instr = 16'h0210;                       // would write r2 if taken
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 16'hDEAD;
    check(ready === 1'b0, "R6", ready, 0);
    @(negedge clk);
    cfg_we = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    instr_valid = 1'b0;
    check(lat == 5, "R5", lat, 5);
    peek(0, v);
    check(v === reg_val(0, 5), "R8", v, reg_val(0, 5));
    peek(2, v);
    check(v === reg_val(2, 5), "R6", v, reg_val(2, 5));
    a = mem_val(int'(reg_val(2, 5))) + mem_val(int'(reg_val(1, 5)));
    peek(1, v);
    check(v === a, "R3", v, a);
    @(negedge clk);
    check(done === 1'b0 && ready === 1'b1, "R6", {done, ready}, 1);

    // R8: load accepted while idle
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd6; cfg_wdata = 16'hBEEF;
    @(negedge clk);
    cfg_we = 1'b0;
    peek(6, v);
    check(v === 16'hBEEF, "R8", v, 16'hBEEF);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule